// File: doc/BRIEF.md
# Backplane Command Decoder

This block sits between a shared instrumentation backplane and the buffers of a serial communications module. Each backplane cycle presents a station select, a 5-bit function code and a 4-bit subaddress. The block turns that pair into one access to a data FIFO, a control FIFO, an 8-bit register or an interrupt register. It answers every cycle with an accept flag and a condition flag, and drives a 16-bit read word back to the backplane. Side effects go to the neighbouring blocks as single-cycle pulses.

Writes act on the rising edge of the first (write) strobe. Reads act on the rising edge of the second (read) strobe. The condition flag carries the state of the addressed resource, so the backplane master can tell whether a transfer happened: data waiting, room to write, register ready, or the attention line level. Module initialisation can come from one addressed function code or from a crate-wide clear that needs no station select. A configuration input picks 8-bit or 16-bit transfers on the data FIFO ports.

Top module: `bus_cmd_decoder`

## Requirements
- R1: `cmdAccept` is 1 when `stationSel` is 1 and the (function, subaddress) pair is one of: (0,0), (0,1), (16,0), (16,1), (1,1), (17,1), (1,14), (1,13), (17,13), (1,12), (8,15), (25,15). In every other case it is 0.
- R2: `cmdCond` gives the state of the addressed resource: `rxDataAvail` for (0,0), `rxCtrlAvail` for (0,1), `txDataSpace` for (16,0), `txCtrlSpace` for (16,1), `outRegFull` for (1,1), `inRegEmpty` for (17,1) and `attnState` for (8,15). It is 0 for the interrupt register commands (1,14), (1,13), (17,13), (1,12), for (25,15), and whenever `cmdAccept` is 0.
- R3: A write effect (`txDataPush`, `txCtrlPush`, `inRegLoad`, `maskLoad`) pulses for exactly one cycle, in the cycle where `strobeWr` rises. A read effect (`rxDataPop`, `rxCtrlPop`, `outRegTaken`) pulses for exactly one cycle, in the cycle where `strobeRd` rises. Holding a strobe high gives no further pulse, and the other strobe gives none.
- R4: A push, pop or register load happens only when the command's condition is 1. When the condition is 0, the strobe has no effect.
- R5: `rdData` returns the receive data word for (0,0), the receive control word for (0,1), the output register byte for (1,1), the request bits for (1,14), the mask bits for (1,13) and the status bits for (1,12), each zero-extended to 16 bits. It is 0 for every other case.
- R6: When `byteMode` is 1, a data FIFO read returns only bits 7:0 of `rxDataWord`, and `txDataWord` carries only bits 7:0 of `wrData`, with the upper byte zero. The control FIFO ports always pass all 16 bits.
- R7: `moduleInit` pulses for one cycle when `strobeWr` rises on (25,15) with the station selected. It also pulses when `strobeRd` rises while `busClear` is 1, whatever the station select.
- R8: A read of the output register (1,1) pulses `outRegTaken` on the rising edge of `strobeRd`, which clears the matching interrupt status.
- R9: A (17,13) write pulses `maskLoad` with `maskWord` equal to the low 5 bits of `wrData`. (17,1) pulses `inRegLoad` with `inRegByte` equal to `wrData[7:0]`.
- R10: With `stationSel` at 0, no effect pulses except the crate clear of R7, and `rdData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stationSel | input | 1 | Backplane cycle addresses this station |
| funcCode | input | 5 | Function code |
| subAddr | input | 4 | Subaddress |
| strobeWr | input | 1 | First strobe; writes act on its rise |
| strobeRd | input | 1 | Second strobe; reads act on its rise |
| busClear | input | 1 | Crate-wide clear level |
| wrData | input | 16 | Write data from the backplane |
| byteMode | input | 1 | 1 selects 8-bit data FIFO transfers |
| cmdAccept | output | 1 | Command recognised |
| cmdCond | output | 1 | Per-command condition |
| rdData | output | 16 | Read data to the backplane |
| rxDataWord | input | 16 | Head of the receive data FIFO |
| rxDataAvail | input | 1 | Receive data FIFO not empty |
| rxDataPop | output | 1 | Pop receive data FIFO |
| rxCtrlWord | input | 16 | Head of the receive control FIFO |
| rxCtrlAvail | input | 1 | Receive control FIFO not empty |
| rxCtrlPop | output | 1 | Pop receive control FIFO |
| txDataSpace | input | 1 | Transmit data FIFO has room |
| txDataPush | output | 1 | Push transmit data FIFO |
| txDataWord | output | 16 | Word for the transmit data FIFO |
| txCtrlSpace | input | 1 | Transmit control FIFO has room |
| txCtrlPush | output | 1 | Push transmit control FIFO |
| txCtrlWord | output | 16 | Word for the transmit control FIFO |
| outRegByte | input | 8 | Processor-to-backplane register |
| outRegFull | input | 1 | Output register holds unread data |
| outRegTaken | output | 1 | Output register read; clear its status |
| inRegEmpty | input | 1 | Backplane-to-processor register ready |
| inRegLoad | output | 1 | Load input register |
| inRegByte | output | 8 | Byte for the input register |
| reqBits | input | 5 | Interrupt request register |
| maskBits | input | 5 | Interrupt mask register |
| maskLoad | output | 1 | Load mask register |
| maskWord | output | 5 | New mask value |
| statusBits | input | 12 | Module status register |
| attnState | input | 1 | Attention request level |
| moduleInit | output | 1 | Initialise module |

## Verification
The bench holds a strobe high for several cycles. A decoder that used strobe levels instead of edges would pop or push more than once, and the scoreboard would see effects it never expected. Pushes and loads are driven against a full FIFO or a busy register, where a design that ignored the condition would emit a push that must not exist. A data-port command under the wrong strobe and a crate clear with the station deselected probe strobe routing. Byte mode is applied to both data and control ports: a design that truncated the control path, or forgot to clear the upper byte, returns a wrong word.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;
  localparam int FUNC_W = 5;
  localparam int SUB_W  = 4;

  localparam logic [FUNC_W-1:0] FN_FIFO_RD = 5'd0;
  localparam logic [FUNC_W-1:0] FN_REG_RD  = 5'd1;
  localparam logic [FUNC_W-1:0] FN_ATTN    = 5'd8;
  localparam logic [FUNC_W-1:0] FN_FIFO_WR = 5'd16;
  localparam logic [FUNC_W-1:0] FN_REG_WR  = 5'd17;
  localparam logic [FUNC_W-1:0] FN_INIT    = 5'd25;

  localparam logic [SUB_W-1:0] SA_DATA = 4'd0;
  localparam logic [SUB_W-1:0] SA_CTRL = 4'd1;
  localparam logic [SUB_W-1:0] SA_STAT = 4'd12;
  localparam logic [SUB_W-1:0] SA_MASK = 4'd13;
  localparam logic [SUB_W-1:0] SA_REQ  = 4'd14;
  localparam logic [SUB_W-1:0] SA_CMD  = 4'd15;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RX_DATA, SEL_RX_CTRL, SEL_TX_DATA, SEL_TX_CTRL,
    SEL_OUT_REG, SEL_IN_REG, SEL_REQ_RD, SEL_MASK_RD, SEL_MASK_WR,
    SEL_STAT_RD, SEL_ATTN, SEL_INIT
  } cmdSel_t;

  typedef struct packed {
    cmdSel_t sel;
    logic    accept;
  } cmdRoute_t;

  typedef struct packed {
    logic moduleInit;
    logic maskLoad;
    logic inRegLoad;
    logic outRegTaken;
    logic txCtrlPush;
    logic rxCtrlPop;
    logic txDataPush;
    logic rxDataPop;
  } cmdStrobes_t;
endpackage

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
  import bus_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stationSel,
  input  logic [FUNC_W-1:0] funcCode,
  input  logic [SUB_W-1:0]  subAddr,
  input  logic              strobeWr,
  input  logic              strobeRd,
  input  logic              busClear,
  input  logic              condIn,
  output cmdRoute_t         route,
  output cmdStrobes_t       strobes
);
  cmdSel_t sel;
  logic    wrPrev, rdPrev;
  logic    wrRise, rdRise;

  always_comb begin
    sel = SEL_NONE;
    if (stationSel) begin
      case (funcCode)
        FN_FIFO_RD: begin
          if (subAddr == SA_DATA)      sel = SEL_RX_DATA;
          else if (subAddr == SA_CTRL) sel = SEL_RX_CTRL;
        end
        FN_FIFO_WR: begin
          if (subAddr == SA_DATA)      sel = SEL_TX_DATA;
          else if (subAddr == SA_CTRL) sel = SEL_TX_CTRL;
        end
        FN_REG_RD: begin
          if (subAddr == SA_CTRL)      sel = SEL_OUT_REG;
          else if (subAddr == SA_REQ)  sel = SEL_REQ_RD;
          else if (subAddr == SA_MASK) sel = SEL_MASK_RD;
          else if (subAddr == SA_STAT) sel = SEL_STAT_RD;
        end
        FN_REG_WR: begin
          if (subAddr == SA_CTRL)      sel = SEL_IN_REG;
          else if (subAddr == SA_MASK) sel = SEL_MASK_WR;
        end
        FN_ATTN: if (subAddr == SA_CMD) sel = SEL_ATTN;
        FN_INIT: if (subAddr == SA_CMD) sel = SEL_INIT;
        default: sel = SEL_NONE;
      endcase
    end
  end

  assign route.sel    = sel;
  assign route.accept = (sel != SEL_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPrev <= 1'b0;
      rdPrev <= 1'b0;
    end else begin
      wrPrev <= strobeWr;
      rdPrev <= strobeRd;
    end
  end

  assign wrRise = strobeWr & ~wrPrev;
  assign rdRise = strobeRd & ~rdPrev;

  always_comb begin
    strobes.rxDataPop   = rdRise && sel == SEL_RX_DATA && condIn;
    strobes.rxCtrlPop   = rdRise && sel == SEL_RX_CTRL && condIn;
    strobes.outRegTaken = rdRise && sel == SEL_OUT_REG && condIn;
    strobes.txDataPush  = wrRise && sel == SEL_TX_DATA && condIn;
    strobes.txCtrlPush  = wrRise && sel == SEL_TX_CTRL && condIn;
    strobes.inRegLoad   = wrRise && sel == SEL_IN_REG && condIn;
    strobes.maskLoad    = wrRise && sel == SEL_MASK_WR;
    strobes.moduleInit  = (wrRise && sel == SEL_INIT) || (rdRise && busClear);
  end
endmodule

// File: rtl/bus_cmd_datapath.sv
module bus_cmd_datapath
  import bus_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int REQ_W  = 5,
  parameter int STAT_W = 12
) (
  input  cmdRoute_t          route,
  input  logic               byteMode,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DATA_W-1:0]  rxDataWord,
  input  logic               rxDataAvail,
  input  logic [DATA_W-1:0]  rxCtrlWord,
  input  logic               rxCtrlAvail,
  input  logic               txDataSpace,
  input  logic               txCtrlSpace,
  input  logic [BYTE_W-1:0]  outRegByte,
  input  logic               outRegFull,
  input  logic               inRegEmpty,
  input  logic [REQ_W-1:0]   reqBits,
  input  logic [REQ_W-1:0]   maskBits,
  input  logic [STAT_W-1:0]  statusBits,
  input  logic               attnState,
  output logic               cmdCond,
  output logic [DATA_W-1:0]  rdData,
  output logic [DATA_W-1:0]  txDataWord,
  output logic [DATA_W-1:0]  txCtrlWord,
  output logic [BYTE_W-1:0]  inRegByte,
  output logic [REQ_W-1:0]   maskWord
);
  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'({BYTE_W{1'b1}});

  logic [DATA_W-1:0] rxDataFmt;

  assign rxDataFmt  = byteMode ? (rxDataWord & LOW_MASK) : rxDataWord;
  assign txDataWord = byteMode ? (wrData & LOW_MASK) : wrData;
  assign txCtrlWord = wrData;
  assign inRegByte  = wrData[BYTE_W-1:0];
  assign maskWord   = wrData[REQ_W-1:0];

  always_comb begin
    case (route.sel)
      SEL_RX_DATA: cmdCond = rxDataAvail;
      SEL_RX_CTRL: cmdCond = rxCtrlAvail;
      SEL_TX_DATA: cmdCond = txDataSpace;
      SEL_TX_CTRL: cmdCond = txCtrlSpace;
      SEL_OUT_REG: cmdCond = outRegFull;
      SEL_IN_REG:  cmdCond = inRegEmpty;
      SEL_ATTN:    cmdCond = attnState;
      default:     cmdCond = 1'b0;
    endcase
  end

  always_comb begin
    case (route.sel)
      SEL_RX_DATA: rdData = rxDataFmt;
      SEL_RX_CTRL: rdData = rxCtrlWord;
      SEL_OUT_REG: rdData = DATA_W'(outRegByte);
      SEL_REQ_RD:  rdData = DATA_W'(reqBits);
      SEL_MASK_RD: rdData = DATA_W'(maskBits);
      SEL_STAT_RD: rdData = DATA_W'(statusBits);
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder
  import bus_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int REQ_W  = 5,
  parameter int STAT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stationSel,
  input  logic [4:0]        funcCode,
  input  logic [3:0]        subAddr,
  input  logic              strobeWr,
  input  logic              strobeRd,
  input  logic              busClear,
  input  logic [DATA_W-1:0] wrData,
  input  logic              byteMode,
  output logic              cmdAccept,
  output logic              cmdCond,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] rxDataWord,
  input  logic              rxDataAvail,
  output logic              rxDataPop,
  input  logic [DATA_W-1:0] rxCtrlWord,
  input  logic              rxCtrlAvail,
  output logic              rxCtrlPop,
  input  logic              txDataSpace,
  output logic              txDataPush,
  output logic [DATA_W-1:0] txDataWord,
  input  logic              txCtrlSpace,
  output logic              txCtrlPush,
  output logic [DATA_W-1:0] txCtrlWord,
  input  logic [BYTE_W-1:0] outRegByte,
  input  logic              outRegFull,
  output logic              outRegTaken,
  input  logic              inRegEmpty,
  output logic              inRegLoad,
  output logic [BYTE_W-1:0] inRegByte,
  input  logic [REQ_W-1:0]  reqBits,
  input  logic [REQ_W-1:0]  maskBits,
  output logic              maskLoad,
  output logic [REQ_W-1:0]  maskWord,
  input  logic [STAT_W-1:0] statusBits,
  input  logic              attnState,
  output logic              moduleInit
);
  cmdRoute_t   route;
  cmdStrobes_t strobes;
  logic        condInt;

  bus_cmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .stationSel(stationSel), .funcCode(funcCode),
    .subAddr(subAddr), .strobeWr(strobeWr), .strobeRd(strobeRd),
    .busClear(busClear), .condIn(condInt), .route(route), .strobes(strobes)
  );

  bus_cmd_datapath #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .REQ_W(REQ_W), .STAT_W(STAT_W)
  ) u_dp (
    .route(route), .byteMode(byteMode), .wrData(wrData),
    .rxDataWord(rxDataWord), .rxDataAvail(rxDataAvail),
    .rxCtrlWord(rxCtrlWord), .rxCtrlAvail(rxCtrlAvail),
    .txDataSpace(txDataSpace), .txCtrlSpace(txCtrlSpace),
    .outRegByte(outRegByte), .outRegFull(outRegFull), .inRegEmpty(inRegEmpty),
    .reqBits(reqBits), .maskBits(maskBits), .statusBits(statusBits),
    .attnState(attnState), .cmdCond(condInt), .rdData(rdData),
    .txDataWord(txDataWord), .txCtrlWord(txCtrlWord), .inRegByte(inRegByte),
    .maskWord(maskWord)
  );

  assign cmdAccept   = route.accept;
  assign cmdCond     = condInt;
  assign rxDataPop   = strobes.rxDataPop;
  assign rxCtrlPop   = strobes.rxCtrlPop;
  assign txDataPush  = strobes.txDataPush;
  assign txCtrlPush  = strobes.txCtrlPush;
  assign outRegTaken = strobes.outRegTaken;
  assign inRegLoad   = strobes.inRegLoad;
  assign maskLoad    = strobes.maskLoad;
  assign moduleInit  = strobes.moduleInit;
endmodule

// File: rtl/bus_cmd_decoder_chk.sv
module bus_cmd_decoder_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobeWr,
  input logic              strobeRd,
  input logic              cmdAccept,
  input logic              cmdCond,
  input logic [DATA_W-1:0] rdData,
  input logic              rxDataPop,
  input logic              rxCtrlPop,
  input logic              txDataPush,
  input logic              txCtrlPush,
  input logic              outRegTaken,
  input logic              inRegLoad,
  input logic              maskLoad,
  input logic              txDataSpace,
  input logic              rxDataAvail,
  input logic              outRegFull,
  input logic              inRegEmpty
);
  logic anyWrEff, anyRdEff;
  assign anyWrEff = txDataPush | txCtrlPush | inRegLoad | maskLoad;
  assign anyRdEff = rxDataPop | rxCtrlPop | outRegTaken;

  AST_NO_ACCEPT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdAccept |-> !(anyWrEff || anyRdEff)); // R10
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdAccept |-> (rdData == '0 && !cmdCond)); // R5
  AST_WRITE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    anyWrEff |-> (strobeWr && !$past(strobeWr))); // R3
  AST_READ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    anyRdEff |-> (strobeRd && !$past(strobeRd))); // R3
  AST_SINGLE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rxDataPop, rxCtrlPop, txDataPush, txCtrlPush, outRegTaken, inRegLoad, maskLoad})); // R3
  AST_PUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    txDataPush |=> !txDataPush); // R3
  AST_PUSH_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    txDataPush |-> txDataSpace); // R4
  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rxDataPop |-> rxDataAvail); // R4
  AST_REG_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (outRegTaken |-> outRegFull) and (inRegLoad |-> inRegEmpty)); // R8
endmodule

bind bus_cmd_decoder bus_cmd_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobeWr(strobeWr), .strobeRd(strobeRd),
  .cmdAccept(cmdAccept), .cmdCond(cmdCond), .rdData(rdData),
  .rxDataPop(rxDataPop), .rxCtrlPop(rxCtrlPop), .txDataPush(txDataPush),
  .txCtrlPush(txCtrlPush), .outRegTaken(outRegTaken), .inRegLoad(inRegLoad),
  .maskLoad(maskLoad), .txDataSpace(txDataSpace), .rxDataAvail(rxDataAvail),
  .outRegFull(outRegFull), .inRegEmpty(inRegEmpty)
);

// File: tb/tb_bus_cmd_decoder.sv
module tb_bus_cmd_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stationSel = 0, strobeWr = 0, strobeRd = 0, busClear = 0, byteMode = 0;
  logic [4:0]  funcCode = '0;
  logic [3:0]  subAddr = '0;
  logic [15:0] wrData = '0, rxDataWord = '0, rxCtrlWord = '0;
  logic rxDataAvail = 0, rxCtrlAvail = 0, txDataSpace = 0, txCtrlSpace = 0;
  logic [7:0]  outRegByte = '0;
  logic outRegFull = 0, inRegEmpty = 0, attnState = 0;
  logic [4:0]  reqBits = '0, maskBits = '0;
  logic [11:0] statusBits = '0;
  logic cmdAccept, cmdCond, rxDataPop, rxCtrlPop, txDataPush, txCtrlPush;
  logic outRegTaken, inRegLoad, maskLoad, moduleInit;
  logic [15:0] rdData, txDataWord, txCtrlWord;
  logic [7:0]  inRegByte;
  logic [4:0]  maskWord;

  always #4 clk = ~clk;

  bus_cmd_decoder dut (.*);

  // effect vector bits: 0 rxDataPop, 1 txDataPush, 2 rxCtrlPop, 3 txCtrlPush,
  // 4 outRegTaken, 5 inRegLoad, 6 maskLoad, 7 moduleInit
  localparam logic [7:0] E_RXD = 8'h01, E_TXD = 8'h02, E_RXC = 8'h04, E_TXC = 8'h08;
  localparam logic [7:0] E_OUT = 8'h10, E_IN = 8'h20, E_MSK = 8'h40, E_INIT = 8'h80;

  typedef struct { logic [7:0] vec; logic [15:0] word; string tag; } expItem_t;
  expItem_t expQ[$];
  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0]  obsVec;
  logic [15:0] obsWord;
  expItem_t    head;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // monitor: pops expected effects as pulses appear
  initial forever begin
    @(negedge clk); #2;
    if (rst_n) begin
      obsVec = {moduleInit, maskLoad, inRegLoad, outRegTaken,
                txCtrlPush, rxCtrlPop, txDataPush, rxDataPop};
      obsWord = txDataPush ? txDataWord : txCtrlPush ? txCtrlWord :
                inRegLoad ? {8'h0, inRegByte} : maskLoad ? {11'h0, maskWord} : 16'h0;
      if (obsVec != 0) begin
        if (expQ.size() == 0) chk("R3 unexpected effect", {16'h0, obsWord, obsVec}, 32'h0);
        else begin
          head = expQ.pop_front();
          chk({head.tag, " effect"}, {24'h0, obsVec}, {24'h0, head.vec});
          chk({head.tag, " word"}, {16'h0, obsWord}, {16'h0, head.word});
        end
      end
    end
  end

  // kind: 0 no strobe, 1 write strobe, 2 read strobe
  task automatic doCmd(string tag, bit stn, logic [4:0] f, logic [3:0] a, logic [15:0] wd,
                       int kind, bit clr, logic expAcc, logic expCond, logic [15:0] expRd,
                       logic [7:0] expVec, logic [15:0] expWord, int hold);
    @(negedge clk);
    stationSel = stn; funcCode = f; subAddr = a; wrData = wd; busClear = clr;
    #2;
    chk({tag, " accept"}, {31'h0, cmdAccept}, {31'h0, expAcc});
    chk({tag, " cond"}, {31'h0, cmdCond}, {31'h0, expCond});
    chk({tag, " rdData"}, {16'h0, rdData}, {16'h0, expRd});
    if (expVec != 0) expQ.push_back('{vec: expVec, word: expWord, tag: tag});
    @(negedge clk);
    if (kind == 1) strobeWr = 1;
    if (kind == 2) strobeRd = 1;
    repeat (hold) @(negedge clk);
    strobeWr = 0; strobeRd = 0;
    @(negedge clk);
    stationSel = 0; busClear = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset accept", {31'h0, cmdAccept}, 32'h0);
    chk("R10 reset effects", {24'h0, moduleInit, maskLoad, inRegLoad, outRegTaken,
        txCtrlPush, rxCtrlPop, txDataPush, rxDataPop}, 32'h0);
    rst_n = 1;
    rxDataWord = 16'hA55A; rxDataAvail = 1; rxCtrlWord = 16'h0F0F; rxCtrlAvail = 1;
    txDataSpace = 1; txCtrlSpace = 1; outRegByte = 8'hC3; outRegFull = 1; inRegEmpty = 1;
    reqBits = 5'b10101; maskBits = 5'b01100; statusBits = 12'hABC;

    doCmd("R5 rx data read", 1, 0, 0, 0, 2, 0, 1, 1, 16'hA55A, E_RXD, 0, 1);
    doCmd("R3 rx data held strobe", 1, 0, 0, 0, 2, 0, 1, 1, 16'hA55A, E_RXD, 0, 3);
    doCmd("R3 rx data on write strobe", 1, 0, 0, 0, 1, 0, 1, 1, 16'hA55A, 0, 0, 1);
    byteMode = 1;
    doCmd("R6 rx data byte mode", 1, 0, 0, 0, 2, 0, 1, 1, 16'h005A, E_RXD, 0, 1);
    doCmd("R6 tx data byte mode", 1, 16, 0, 16'h1234, 1, 0, 1, 1, 0, E_TXD, 16'h0034, 1);
    doCmd("R6 rx ctrl full width", 1, 0, 1, 0, 2, 0, 1, 1, 16'h0F0F, E_RXC, 0, 1);
    doCmd("R6 tx ctrl full width", 1, 16, 1, 16'h8001, 1, 0, 1, 1, 0, E_TXC, 16'h8001, 1);
    byteMode = 0;
    doCmd("R2 tx data word mode", 1, 16, 0, 16'hBEEF, 1, 0, 1, 1, 0, E_TXD, 16'hBEEF, 2);
    txDataSpace = 0;
    doCmd("R4 tx data full", 1, 16, 0, 16'h1111, 1, 0, 1, 0, 0, 0, 0, 1);
    rxDataAvail = 0;
    doCmd("R4 rx data empty", 1, 0, 0, 0, 2, 0, 1, 0, 16'hA55A, 0, 0, 1);
    doCmd("R8 output reg read", 1, 1, 1, 0, 2, 0, 1, 1, 16'h00C3, E_OUT, 0, 1);
    doCmd("R9 input reg write", 1, 17, 1, 16'h1277, 1, 0, 1, 1, 0, E_IN, 16'h0077, 1);
    inRegEmpty = 0;
    doCmd("R4 input reg busy", 1, 17, 1, 16'h1277, 1, 0, 1, 0, 0, 0, 0, 1);
    doCmd("R5 request read", 1, 1, 14, 0, 2, 0, 1, 0, 16'h0015, 0, 0, 1);
    doCmd("R5 mask read", 1, 1, 13, 0, 2, 0, 1, 0, 16'h000C, 0, 0, 1);
    doCmd("R9 mask write", 1, 17, 13, 16'hFFF3, 1, 0, 1, 0, 0, E_MSK, 16'h0013, 1);
    doCmd("R5 status read", 1, 1, 12, 0, 2, 0, 1, 0, 16'h0ABC, 0, 0, 1);
    attnState = 1;
    doCmd("R2 attention high", 1, 8, 15, 0, 2, 0, 1, 1, 0, 0, 0, 1);
    attnState = 0;
    doCmd("R2 attention low", 1, 8, 15, 0, 2, 0, 1, 0, 0, 0, 0, 1);
    doCmd("R7 init command", 1, 25, 15, 0, 1, 0, 1, 0, 0, E_INIT, 0, 1);
    doCmd("R7 crate clear", 0, 0, 0, 0, 2, 1, 0, 0, 0, E_INIT, 0, 1);
    rxDataAvail = 1;
    doCmd("R10 not selected", 0, 0, 0, 0, 2, 0, 0, 0, 0, 0, 0, 1);
    doCmd("R1 undecoded pair", 1, 2, 0, 0, 2, 0, 0, 0, 0, 0, 0, 1);
    doCmd("R1 undecoded subaddr", 1, 16, 5, 16'h5555, 1, 0, 0, 0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    chk("R3 all expected effects seen", expQ.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule